// File: doc/BRIEF.md
# Display Command Interpreter and Window Addresser

This block sits behind a serial panel link. It takes in 9-bit frames, and each frame carries one byte plus a flag. The flag separates command opcodes from the argument bytes that follow them. The block decodes the opcodes into a configuration record: the column window, the row window, the scan-order byte, the pixel format, the gamma curve and four mode flags. These are published as outputs for the scanout stage.

After a memory-write opcode, argument bytes are treated as pixel data. They are grouped into pixels according to the pixel format and widened to 18 bits. Each pixel is written to frame memory at an address that walks the programmed window. Register-tuning opcodes (power, voltage, gamma tables) take their bytes in silently and change nothing.

Top module: `disp_cmd_window`

## Requirements
- R1: Bit 8 of `frame_data` selects the frame type: 0 means a command opcode and 1 means an argument byte. An argument never acts as an opcode.
- R2: After reset the block holds these values:
  - column window 0x0000..0x013F and row window 0x0000..0x00EF
  - `acc_ctrl` = 0x08 and `pix_fmt` = 2 (18 bpp) and `gamma_sel` = 1
  - `sleep_on` = 1, with `disp_on`, `invert_on` and `idle_on` all 0
  - `pix_we` = 0
- R3: Opcode 0x2A takes four arguments: start column high byte, start column low byte, end column high byte, end column low byte. Both bounds are inclusive.
- R4: Opcode 0x2B takes the start row and the end row in the same big-endian four-byte layout. Both bounds are inclusive.
- R5: Opcode 0x36 loads `acc_ctrl` from one argument, and the bits act as follows:
  - bit 3 set: the red and blue fields of `pix_data` are exchanged
  - bit 5 set: the walk steps rows before columns
  - bit 6 set: columns are walked from end to start
  - bit 7 set: rows are walked from end to start
- R6: Opcode 0x3A sets `pix_fmt` from bits 2:0 of its argument, and all higher bits are ignored. A value of 3 gives 12 bpp (`pix_fmt` 0) and 5 gives 16 bpp (1). Every other value gives 18 bpp (2).
- R7: Opcode 0x26 stores its argument in `gamma_sel` if the argument is 1, 2, 4 or 8. Any other value stores 1.
- R8: Opcode 0x01 restores every reset value of R2.
- R9: Opcode 0x2C moves the pointer to the first corner of the window. Every completed pixel drives `pix_we` high for one cycle, one clock after its last byte, with `pix_addr` = row*COLS + column. The pointer then advances and wraps inside the window in both directions.
- R10: At 18 bpp a pixel is three bytes in the order red, green, blue. The upper six bits of each byte are used, and `pix_data` = {red, green, blue}.
- R11: At 16 bpp a pixel is two bytes laid out RRRRRGGG then GGGBBBBB. Red and blue are widened by appending their MSB.
- R12: At 12 bpp three bytes carry two pixels as nibbles: R1G1, B1R2, G2B2. Each nibble n is widened to {n, n[3:2]}.
- R13: The following are discarded:
  - argument bytes beyond the count an opcode expects
  - arguments of unlisted opcodes
  - pixel bytes that arrive after any other opcode has ended a memory write
- R14: The mode opcodes act as follows:
  - 0x10 sets `sleep_on` and 0x11 clears it
  - 0x29 sets `disp_on` and 0x28 clears it
  - 0x21 sets `invert_on` and 0x20 clears it
  - 0x39 sets `idle_on` and 0x38 clears it

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | A frame is present this cycle |
| frame_data | input | 9 | Bit 8 = argument flag, bits 7:0 = byte |
| pix_we | output | 1 | Frame-memory write strobe |
| pix_addr | output | AW | Frame-memory word address |
| pix_data | output | 18 | Pixel, 6 bits per colour |
| col_start | output | 16 | Window first column |
| col_end | output | 16 | Window last column |
| row_start | output | 16 | Window first row |
| row_end | output | 16 | Window last row |
| acc_ctrl | output | 8 | Scan-order and colour-order byte |
| pix_fmt | output | 2 | 0 = 12 bpp, 1 = 16 bpp, 2 = 18 bpp |
| gamma_sel | output | 4 | Selected gamma curve |
| sleep_on | output | 1 | Sleep flag |
| disp_on | output | 1 | Display enable flag |
| invert_on | output | 1 | Colour inversion flag |
| idle_on | output | 1 | Reduced-colour flag |

## Verification
The bench builds the block with its default geometry of 320 columns by 240 rows. With that geometry, the reset window bounds are 0x013F and 0x00EF, and every expected address uses a 320-word row pitch. Inside that geometry the bench programs a two-by-two window, so that column wrap, row wrap, reversed order and row-first order each occur within a handful of pixels. It then checks the byte-to-pixel grouping at all three pixel formats.

// File: rtl/disp_cmd_window.sv
module disp_cmd_window #(
  parameter int COLS = 320,
  parameter int ROWS = 240,
  localparam int AW = $clog2(COLS * ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_valid,
  input  logic [8:0]    frame_data,
  output logic          pix_we,
  output logic [AW-1:0] pix_addr,
  output logic [17:0]   pix_data,
  output logic [15:0]   col_start,
  output logic [15:0]   col_end,
  output logic [15:0]   row_start,
  output logic [15:0]   row_end,
  output logic [7:0]    acc_ctrl,
  output logic [1:0]    pix_fmt,
  output logic [3:0]    gamma_sel,
  output logic          sleep_on,
  output logic          disp_on,
  output logic          invert_on,
  output logic          idle_on
);

  localparam logic [1:0] F12 = 2'd0, F16 = 2'd1, F18 = 2'd2;

  typedef struct packed {
    logic [15:0] cs, ce, rs, re;
    logic [7:0]  mac;
    logic [1:0]  fmt;
    logic [3:0]  gam;
    logic        slp, dsp, inv, idl;
  } cfg_t;

  localparam cfg_t CFG_DEF = '{cs: 16'd0, ce: 16'(COLS - 1), rs: 16'd0, re: 16'(ROWS - 1),
                               mac: 8'h08, fmt: F18, gam: 4'd1,
                               slp: 1'b1, dsp: 1'b0, inv: 1'b0, idl: 1'b0};

  cfg_t        cfg;
  logic [7:0]  cmd_q;
  logic [2:0]  pidx;
  logic        mem_wr;
  logic [1:0]  phase;
  logic [7:0]  hold0, hold1;
  logic [15:0] cur_col, cur_row, nxt_col, nxt_row;

  wire       is_cmd = frame_valid & ~frame_data[8];
  wire       is_par = frame_valid &  frame_data[8];
  wire [7:0] pb     = frame_data[7:0];

  assign col_start = cfg.cs;
  assign col_end   = cfg.ce;
  assign row_start = cfg.rs;
  assign row_end   = cfg.re;
  assign acc_ctrl  = cfg.mac;
  assign pix_fmt   = cfg.fmt;
  assign gamma_sel = cfg.gam;
  assign sleep_on  = cfg.slp;
  assign disp_on   = cfg.dsp;
  assign invert_on = cfg.inv;
  assign idle_on   = cfg.idl;

  wire mv = cfg.mac[5];
  wire mx = cfg.mac[6];
  wire my = cfg.mac[7];

  wire [15:0] col_first = mx ? cfg.ce : cfg.cs;
  wire [15:0] col_last  = mx ? cfg.cs : cfg.ce;
  wire [15:0] row_first = my ? cfg.re : cfg.rs;
  wire [15:0] row_last  = my ? cfg.rs : cfg.re;
  wire [15:0] col_step  = mx ? cur_col - 16'd1 : cur_col + 16'd1;
  wire [15:0] row_step  = my ? cur_row - 16'd1 : cur_row + 16'd1;
  wire        col_wrap  = (cur_col == col_last);
  wire        row_wrap  = (cur_row == row_last);

  always_comb begin
    nxt_col = cur_col;
    nxt_row = cur_row;
    if (!mv) begin
      if (col_wrap) begin
        nxt_col = col_first;
        nxt_row = row_wrap ? row_first : row_step;
      end else begin
        nxt_col = col_step;
      end
    end else begin
      if (row_wrap) begin
        nxt_row = row_first;
        nxt_col = col_wrap ? col_first : col_step;
      end else begin
        nxt_row = row_step;
      end
    end
  end

  function automatic logic [5:0] wid4(input logic [3:0] n);
    return {n, n[3:2]};
  endfunction

  logic       px_done;
  logic [5:0] px_r, px_g, px_b;

  always_comb begin
    px_done = 1'b0;
    px_r = '0; px_g = '0; px_b = '0;
    case (cfg.fmt)
      F12: begin
        if (phase == 2'd1) begin
          px_done = 1'b1;
          px_r = wid4(hold0[7:4]); px_g = wid4(hold0[3:0]); px_b = wid4(pb[7:4]);
        end else if (phase == 2'd2) begin
          px_done = 1'b1;
          px_r = wid4(hold1[3:0]); px_g = wid4(pb[7:4]); px_b = wid4(pb[3:0]);
        end
      end
      F16: begin
        if (phase == 2'd1) begin
          px_done = 1'b1;
          px_r = {hold0[7:3], hold0[7]};
          px_g = {hold0[2:0], pb[7:5]};
          px_b = {pb[4:0], pb[4]};
        end
      end
      default: begin
        if (phase == 2'd2) begin
          px_done = 1'b1;
          px_r = hold0[7:2]; px_g = hold1[7:2]; px_b = pb[7:2];
        end
      end
    endcase
  end

  wire       phase_end = (phase == 2'd2) || (cfg.fmt == F16 && phase == 2'd1);
  wire [AW-1:0] cur_addr = AW'(cur_row) * AW'(COLS) + AW'(cur_col);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= 8'h00;
      pidx     <= 3'd0;
      mem_wr   <= 1'b0;
      phase    <= 2'd0;
      hold0    <= 8'h00;
      hold1    <= 8'h00;
      cur_col  <= 16'd0;
      cur_row  <= 16'd0;
      pix_we   <= 1'b0;
      pix_addr <= '0;
      pix_data <= '0;
    end else begin
      pix_we <= 1'b0;
      if (is_cmd) begin
        cmd_q  <= pb;
        pidx   <= 3'd0;
        phase  <= 2'd0;
        mem_wr <= (pb == 8'h2C);
        if (pb == 8'h2C) begin
          cur_col <= col_first;
          cur_row <= row_first;
        end
      end else if (is_par) begin
        if (pidx != 3'd7) pidx <= pidx + 3'd1;
        if (mem_wr) begin
          phase <= phase_end ? 2'd0 : phase + 2'd1;
          if (phase == 2'd0) hold0 <= pb;
          if (phase == 2'd1) hold1 <= pb;
          if (px_done) begin
            pix_we   <= 1'b1;
            pix_addr <= cur_addr;
            pix_data <= cfg.mac[3] ? {px_b, px_g, px_r} : {px_r, px_g, px_b};
            cur_col  <= nxt_col;
            cur_row  <= nxt_row;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_DEF;
    end else if (is_cmd) begin
      case (pb)
        8'h01: cfg <= CFG_DEF;
        8'h10: cfg.slp <= 1'b1;
        8'h11: cfg.slp <= 1'b0;
        8'h20: cfg.inv <= 1'b0;
        8'h21: cfg.inv <= 1'b1;
        8'h28: cfg.dsp <= 1'b0;
        8'h29: cfg.dsp <= 1'b1;
        8'h38: cfg.idl <= 1'b0;
        8'h39: cfg.idl <= 1'b1;
        default: ;
      endcase
    end else if (is_par) begin
      case (cmd_q)
        8'h2A: case (pidx)
          3'd0: cfg.cs[15:8] <= pb;
          3'd1: cfg.cs[7:0]  <= pb;
          3'd2: cfg.ce[15:8] <= pb;
          3'd3: cfg.ce[7:0]  <= pb;
          default: ;
        endcase
        8'h2B: case (pidx)
          3'd0: cfg.rs[15:8] <= pb;
          3'd1: cfg.rs[7:0]  <= pb;
          3'd2: cfg.re[15:8] <= pb;
          3'd3: cfg.re[7:0]  <= pb;
          default: ;
        endcase
        8'h36: if (pidx == 3'd0) cfg.mac <= pb;
        8'h3A: if (pidx == 3'd0)
          cfg.fmt <= (pb[2:0] == 3'd3) ? F12 : (pb[2:0] == 3'd5) ? F16 : F18;
        8'h26: if (pidx == 3'd0)
          cfg.gam <= (pb == 8'd1 || pb == 8'd2 || pb == 8'd4 || pb == 8'd8) ? pb[3:0] : 4'd1;
        default: ;
      endcase
    end
  end

endmodule

module disp_cmd_window_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_valid,
  input logic [8:0] frame_data,
  input logic       pix_we,
  input logic [7:0] acc_ctrl,
  input logic [1:0] pix_fmt,
  input logic [3:0] gamma_sel,
  input logic [7:0] cmd_q,
  input logic [2:0] pidx,
  input logic       mem_wr
);

  AST_CMD_NO_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && !frame_data[8] |=> !pix_we); // R1

  AST_PIXEL_FROM_PARAM: assert property (@(posedge clk) disable iff (!rst_n)
    pix_we |-> $past(frame_valid && frame_data[8] && mem_wr)); // R9

  AST_EXTRA_PARAM_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && frame_data[8] && cmd_q == 8'h36 && pidx != 3'd0 |=> $stable(acc_ctrl)); // R13

  AST_GAMMA_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && frame_data[8] && cmd_q == 8'h26 && pidx == 3'd0 |=> $onehot(gamma_sel)); // R7

  AST_FMT_SIXTEEN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && frame_data[8] && cmd_q == 8'h3A && pidx == 3'd0 && frame_data[2:0] == 3'd5
    |=> pix_fmt == 2'd1); // R6

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && frame_data == 9'h001 |=> acc_ctrl == 8'h08 && pix_fmt == 2'd2 && gamma_sel == 4'd1); // R8

endmodule

bind disp_cmd_window disp_cmd_window_chk u_chk (.*);

// File: tb/disp_cmd_window_bench.sv
module disp_cmd_window_bench;
  localparam int COLS = 320;
  localparam int ROWS = 240;
  localparam int AW = $clog2(COLS * ROWS);

  logic clk = 1'b0, rst_n = 1'b0, frame_valid = 1'b0;
  logic [8:0] frame_data = '0;
  logic pix_we;
  logic [AW-1:0] pix_addr;
  logic [17:0] pix_data;
  logic [15:0] col_start, col_end, row_start, row_end;
  logic [7:0] acc_ctrl;
  logic [1:0] pix_fmt;
  logic [3:0] gamma_sel;
  logic sleep_on, disp_on, invert_on, idle_on;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  disp_cmd_window #(.COLS(COLS), .ROWS(ROWS)) u_disp_cmd_window (
    .clk, .rst_n, .frame_valid, .frame_data, .pix_we, .pix_addr, .pix_data,
    .col_start, .col_end, .row_start, .row_end, .acc_ctrl, .pix_fmt, .gamma_sel,
    .sleep_on, .disp_on, .invert_on, .idle_on);

  localparam int NV = 28;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 17'd0, 18'h0, 9'h036}, {1'b0, 17'd0, 18'h0, 9'h100},
    {1'b0, 17'd0, 18'h0, 9'h02A}, {1'b0, 17'd0, 18'h0, 9'h100}, {1'b0, 17'd0, 18'h0, 9'h102},
    {1'b0, 17'd0, 18'h0, 9'h100}, {1'b0, 17'd0, 18'h0, 9'h103},
    {1'b0, 17'd0, 18'h0, 9'h02B}, {1'b0, 17'd0, 18'h0, 9'h100}, {1'b0, 17'd0, 18'h0, 9'h101},
    {1'b0, 17'd0, 18'h0, 9'h100}, {1'b0, 17'd0, 18'h0, 9'h102},
    {1'b0, 17'd0, 18'h0, 9'h02C},
    {1'b0, 17'd0, 18'h0, 9'h1FC}, {1'b0, 17'd0, 18'h0, 9'h100}, {1'b1, 17'd322, 18'h3F001, 9'h104},
    {1'b0, 17'd0, 18'h0, 9'h100}, {1'b0, 17'd0, 18'h0, 9'h1FC}, {1'b1, 17'd323, 18'h00FC0, 9'h100},
    {1'b0, 17'd0, 18'h0, 9'h100}, {1'b0, 17'd0, 18'h0, 9'h100}, {1'b1, 17'd642, 18'h0003F, 9'h1FC},
    {1'b0, 17'd0, 18'h0, 9'h180}, {1'b0, 17'd0, 18'h0, 9'h140}, {1'b1, 17'd643, 18'h20408, 9'h120},
    {1'b0, 17'd0, 18'h0, 9'h104}, {1'b0, 17'd0, 18'h0, 9'h108}, {1'b1, 17'd322, 18'h01083, 9'h10C}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] f);
    @(negedge clk);
    frame_valid = 1'b1;
    frame_data = f;
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic px(input logic [8:0] f, input logic [AW-1:0] a, input logic [17:0] d, input string req);
    send(f);
    chk(pix_we && pix_addr == a && pix_data == d, req,
        {pix_we, pix_addr, pix_data}, {1'b1, a, d});
  endtask

  task automatic nopx(input logic [8:0] f, input string req);
    send(f);
    chk(!pix_we, req, 64'(pix_we), 64'd0);
  endtask

  task automatic chk_defaults(input string req);
    chk(col_start == 16'h0 && col_end == 16'h013F && row_start == 16'h0 && row_end == 16'h00EF,
        req, {col_start, col_end, row_start, row_end}, {16'h0, 16'h013F, 16'h0, 16'h00EF});
    chk(acc_ctrl == 8'h08 && pix_fmt == 2'd2 && gamma_sel == 4'd1, req,
        {acc_ctrl, pix_fmt, gamma_sel}, {8'h08, 2'd2, 4'd1});
    chk({sleep_on, disp_on, invert_on, idle_on, pix_we} == 5'b10000, req,
        {sleep_on, disp_on, invert_on, idle_on, pix_we}, 5'b10000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_defaults("R2 reset");

    // R9 R10: table of window setup and 18 bpp pixels
    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      v = VEC[i];
      send(v[8:0]);
      if (v[44])
        chk(pix_we && pix_addr == v[43:27] && pix_data == v[26:9], "R9/R10 table pixel",
            {pix_we, pix_addr, pix_data}, {1'b1, v[43:27], v[26:9]});
      else
        chk(!pix_we, "R9 table no write", 64'(pix_we), 64'd0);
    end
    chk(col_start == 16'd2 && col_end == 16'd3, "R3 window cols", {col_start, col_end}, {16'd2, 16'd3});
    chk(row_start == 16'd1 && row_end == 16'd2, "R4 window rows", {row_start, row_end}, {16'd1, 16'd2});

    // R5 reversed columns and rows
    send(9'h036); send(9'h1C0); send(9'h02C);
    send(9'h100); send(9'h100); px(9'h1FC, 17'd643, 18'h0003F, "R5 reversed first");
    send(9'h100); send(9'h1FC); px(9'h100, 17'd642, 18'h00FC0, "R5 reversed col step");
    send(9'h100); send(9'h100); px(9'h1FC, 17'd323, 18'h0003F, "R5 reversed row step");
    // R5 row-first walk
    send(9'h036); send(9'h120); send(9'h02C);
    send(9'h100); send(9'h100); px(9'h1FC, 17'd322, 18'h0003F, "R5 row-first start");
    send(9'h100); send(9'h100); px(9'h1FC, 17'd642, 18'h0003F, "R5 row-first step");
    send(9'h100); send(9'h100); px(9'h1FC, 17'd323, 18'h0003F, "R5 row-first col step");
    // R5 colour swap
    send(9'h036); send(9'h108); send(9'h02C);
    send(9'h1FC); send(9'h100); px(9'h100, 17'd322, 18'h0003F, "R5 bgr swap");

    // R13 extra argument discarded
    send(9'h036); send(9'h100); send(9'h1C0);
    chk(acc_ctrl == 8'h00, "R13 extra arg", 64'(acc_ctrl), 64'h0);

    // R6 R11 16 bpp
    send(9'h03A); send(9'h1D5);
    chk(pix_fmt == 2'd1, "R6 code 5", 64'(pix_fmt), 64'd1);
    send(9'h02C);
    send(9'h1F8); px(9'h11F, 17'd322, 18'h3F03F, "R11 16bpp full");
    send(9'h184); px(9'h110, 17'd323, 18'h21821, "R11 16bpp msb copy");

    // R6 R12 12 bpp
    send(9'h03A); send(9'h1F3);
    chk(pix_fmt == 2'd0, "R6 code 3", 64'(pix_fmt), 64'd0);
    send(9'h02C);
    nopx(9'h1F0, "R12 first byte");
    px(9'h15A, 17'd322, 18'h3F015, "R12 pixel one");
    px(9'h13C, 17'd323, 18'h2A333, "R12 pixel two");

    // R6 fallback and ignored upper bits
    send(9'h03A); send(9'h107);
    chk(pix_fmt == 2'd2, "R6 invalid code", 64'(pix_fmt), 64'd2);
    send(9'h03A); send(9'h10B);
    chk(pix_fmt == 2'd0, "R6 msb ignored", 64'(pix_fmt), 64'd0);
    send(9'h03A); send(9'h166);
    chk(pix_fmt == 2'd2, "R6 code 6", 64'(pix_fmt), 64'd2);

    // R7 gamma
    send(9'h026); send(9'h104);
    chk(gamma_sel == 4'd4, "R7 gamma 4", 64'(gamma_sel), 64'd4);
    send(9'h026); send(9'h103);
    chk(gamma_sel == 4'd1, "R7 gamma invalid", 64'(gamma_sel), 64'd1);
    send(9'h026); send(9'h108);
    chk(gamma_sel == 4'd8, "R7 gamma 8", 64'(gamma_sel), 64'd8);

    // R13 tuning opcode ignored, write ended by other opcode
    nopx(9'h0C0, "R13 tuning opcode");
    nopx(9'h12C, "R13 tuning arg");
    chk(acc_ctrl == 8'h00 && pix_fmt == 2'd2, "R13 tuning no effect",
        {acc_ctrl, pix_fmt}, {8'h00, 2'd2});
    send(9'h02C); send(9'h000);
    nopx(9'h1FC, "R13 ended write"); nopx(9'h100, "R13 ended write");
    nopx(9'h104, "R13 ended write");

    // R1 argument never acts as opcode
    send(9'h129);
    chk(disp_on == 1'b0, "R1 arg not opcode", 64'(disp_on), 64'd0);

    // R14 mode flags
    send(9'h011); send(9'h029); send(9'h021); send(9'h039);
    chk({sleep_on, disp_on, invert_on, idle_on} == 4'b0111, "R14 set",
        {sleep_on, disp_on, invert_on, idle_on}, 4'b0111);
    send(9'h010); send(9'h028); send(9'h020); send(9'h038);
    chk({sleep_on, disp_on, invert_on, idle_on} == 4'b1000, "R14 clear",
        {sleep_on, disp_on, invert_on, idle_on}, 4'b1000);

    // R3 big-endian bytes
    send(9'h02A); send(9'h101); send(9'h120); send(9'h101); send(9'h13F);
    chk(col_start == 16'h0120 && col_end == 16'h013F, "R3 big endian",
        {col_start, col_end}, {16'h0120, 16'h013F});

    // R8 soft reset
    send(9'h029); send(9'h026); send(9'h104);
    send(9'h001);
    chk_defaults("R8 soft reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule